// File: doc/BRIEF.md
# Pulse Accumulator Event Counter

This block keeps an 8-bit running total driven by one external input pin. In event mode every active transition of the pin, rising or falling as chosen, adds one to the total. In gated mode the total grows by one for each 64-cycle tick of a free-running divider of the bus clock, but only while the pin is at the chosen active level. The result is a measure of how long the pin has been active.

The pin passes through a two-flop synchronizer and then an edge detector. The total changes only on the rising clock edge, so a read during the low half of the clock always sees a settled value. Software reaches the block through a small register port: the count at address 0, a control byte at address 1 and a flag byte at address 2. Reset clears control and flags. Reset leaves the count unchanged, so a total gathered before a reset is still there after it. Two sticky flags, one for counter wrap and one for pin edges, can each drive the interrupt output through an enable bit.

Top module: `pacc_top`

## Requirements
- R1: Control byte (address 1): bit0 enable, bit1 mode (0 event, 1 gated), bit2 polarity, bit3 wrap interrupt enable, bit4 edge interrupt enable. With enable=1, mode=0 and polarity=0, each rising edge of `pa_in` adds exactly one to the count.
- R2: With enable=1, mode=0 and polarity=1, each falling edge of `pa_in` adds exactly one, and rising edges add nothing.
- R3: With enable=1 and mode=1, the count grows by one for each 64-clock tick while the synchronized pin is at the active level (high for polarity=0, low for polarity=1). An active interval of exactly 64*N cycles adds exactly N. The count does not change while the pin is inactive.
- R4: Reset clears the control byte (reads 0x00), the flag byte (reads 0x00) and `irq`. Reset leaves the count (address 0) unchanged.
- R5: A write to address 0 loads the count at any time. If an increment falls in the same cycle as the write, the written value wins and that increment is lost.
- R6: An increment from 0xFF to 0x00 sets the wrap flag, which is bit0 of the flag byte (address 2).
- R7: Bit1 of the flag byte is the edge flag. In event mode it is set by every counted edge. In gated mode it is set when the pin leaves its active level.
- R8: Writing 1 to a bit of address 2 clears that flag. Writing 0 to a bit leaves that flag unchanged.
- R9: `irq` is high exactly when some flag is set and its enable bit is set (control bit3 for the wrap flag, control bit4 for the edge flag).
- R10: While control bit0 is 0, pin activity leaves both the count and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset; the count is not affected |
| pa_in | input | 1 | Asynchronous external input pin |
| bus_addr | input | 2 | Register select: 0 count, 1 control, 2 flags |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
Event counting is driven with bursts of clean pulses under both polarities, from several preload values. One preload crosses 0xFF, which separates plain counting from wrap-flag generation. A disabled run shows that edges reach neither the count nor the flags. Gated counting uses active intervals that are exact multiples of 64 cycles, so the expected total does not depend on the divider's phase; a long inactive stretch then shows that no ticks leak through. A write held across a gated tick confirms that a write wins over an increment in the same cycle. A reset in the middle of a run shows that the count is preserved while control and flags are cleared.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    localparam int unsigned CNT_W   = 8;
    localparam int unsigned ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] A_COUNT = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd1;
    localparam logic [ADDR_W-1:0] A_FLAGS = 2'd2;

    typedef enum logic {
        MODE_EVENT = 1'b0,
        MODE_GATED = 1'b1
    } pacc_mode_e;

    typedef struct packed {
        logic       edge_ie;
        logic       wrap_ie;
        logic       pol;
        pacc_mode_e mode;
        logic       enable;
    } pacc_ctrl_t;

    localparam int unsigned CTRL_W = $bits(pacc_ctrl_t);

    typedef struct packed {
        logic edge_f;
        logic wrap_f;
    } pacc_flags_t;

    localparam int unsigned FLAGS_W = $bits(pacc_flags_t);

    typedef struct packed {
        logic inc;
        logic edge_evt;
    } pacc_event_t;

    function automatic logic pick_pol(input logic pol, input logic a, input logic b);
        return pol ? b : a;
    endfunction

endpackage

// File: rtl/pacc_insync.sv
module pacc_insync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign lvl  = chain_q[STAGES-1];
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
    parameter int unsigned DIV = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    // no reset: the total survives reset by design
    always_ff @(posedge clk) begin
        if (load)     cnt_q <= load_val;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;
    assign wrap  = inc & ~load & (&cnt_q);

endmodule

// File: rtl/pacc_top.sv
module pacc_top
    import pacc_pkg::*;
#(
    parameter int unsigned PRESCALE    = 64,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pa_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    logic        lvl, rise, fall, tick;
    logic        active_lvl, ev_edge, trail_edge;
    logic        cnt_load, wrap;
    logic [CNT_W-1:0] cnt_q;
    pacc_ctrl_t  ctrl_q;
    pacc_flags_t flags_q;
    pacc_event_t evt;

    pacc_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (pa_in),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    pacc_prescale #(.DIV(PRESCALE)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign active_lvl = pick_pol(ctrl_q.pol, lvl, ~lvl);
    assign ev_edge    = pick_pol(ctrl_q.pol, rise, fall);
    assign trail_edge = pick_pol(ctrl_q.pol, fall, rise);

    always_comb begin
        evt = '0;
        if (ctrl_q.enable) begin
            if (ctrl_q.mode == MODE_EVENT) begin
                evt.inc      = ev_edge;
                evt.edge_evt = ev_edge;
            end else begin
                evt.inc      = tick & active_lvl;
                evt.edge_evt = trail_edge;
            end
        end
    end

    assign cnt_load = bus_wr && (bus_addr == A_COUNT);

    pacc_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .load     (cnt_load),
        .load_val (bus_wdata),
        .inc      (evt.inc),
        .count    (cnt_q),
        .wrap     (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (bus_wr && (bus_addr == A_CTRL)) begin
            ctrl_q <= pacc_ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    logic        flags_clr;
    pacc_flags_t clr_mask;

    assign flags_clr = bus_wr && (bus_addr == A_FLAGS);
    assign clr_mask  = flags_clr ? pacc_flags_t'(bus_wdata[FLAGS_W-1:0]) : '0;

    // a new event wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.wrap_f <= (flags_q.wrap_f & ~clr_mask.wrap_f) | wrap;
            flags_q.edge_f <= (flags_q.edge_f & ~clr_mask.edge_f) | evt.edge_evt;
        end
    end

    always_comb begin
        case (bus_addr)
            A_COUNT: bus_rdata = cnt_q;
            A_CTRL:  bus_rdata = CNT_W'(ctrl_q);
            A_FLAGS: bus_rdata = CNT_W'(flags_q);
            default: bus_rdata = '0;
        endcase
    end

    assign irq = (flags_q.wrap_f & ctrl_q.wrap_ie) | (flags_q.edge_f & ctrl_q.edge_ie);

endmodule

// File: rtl/pacc_checker.sv
module pacc_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] count,
    input logic       en,
    input logic [1:0] flags,
    input logic       irq
);
    logic load;
    assign load = bus_wr && (bus_addr == 2'd0);

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(bus_wdata)) else $error("write lost"); // R5

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> $stable(count)) else $error("count moved while disabled"); // R10

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && count != $past(count)) |-> count == $past(count) + 8'd1)
        else $error("count jumped"); // R1

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && $past(count) == 8'hFF && count == 8'h00) |-> flags[0])
        else $error("wrap flag missing"); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != 2'b00)) else $error("irq without flag"); // R9

endmodule

bind pacc_top pacc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .count     (cnt_q),
    .en        (ctrl_q.enable),
    .flags     (flags_q),
    .irq       (irq)
);

// File: tb/pacc_top_tb.sv
module pacc_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pa_in = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pacc_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .pa_in     (pa_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // {ctrl, preload, pulses, expected count, expected flags}
    localparam logic [39:0] VEC [6] = '{
        {8'h01, 8'h10, 8'd5, 8'h15, 8'h02},
        {8'h05, 8'h00, 8'd3, 8'h03, 8'h02},
        {8'h01, 8'hFD, 8'd4, 8'h01, 8'h03},
        {8'h00, 8'h42, 8'd6, 8'h42, 8'h00},
        {8'h01, 8'hFF, 8'd1, 8'h00, 8'h03},
        {8'h05, 8'h80, 8'd0, 8'h80, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse();
        @(negedge clk); pa_in = 1'b1;
        repeat (4) @(negedge clk);
        pa_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R4 reset state
        rd(2'd1, v); chk("R4 ctrl after reset", v, 8'h00);
        rd(2'd2, v); chk("R4 flags after reset", v, 8'h00);
        chk("R4 irq after reset", {7'b0, irq}, 8'h00);

        // table walk: event mode, both polarities, wrap, disabled
        for (int i = 0; i < 6; i++) begin
            wr(2'd1, 8'h00);
            wr(2'd0, VEC[i][31:24]);
            wr(2'd2, 8'h03);
            wr(2'd1, VEC[i][39:32]);
            for (int p = 0; p < int'(VEC[i][23:16]); p++) pulse();
            repeat (4) @(negedge clk);
            rd(2'd0, v); chk("R1 R2 R10 count", v, VEC[i][15:8]);
            rd(2'd2, v); chk("R6 R7 R10 flags", v, VEC[i][7:0]);
        end

        // R4 count survives reset
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h5A);
        wr(2'd1, 8'h01);
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        rd(2'd0, v); chk("R4 count kept", v, 8'h5A);
        rd(2'd1, v); chk("R4 ctrl cleared", v, 8'h00);

        // R3 gated, active high, 640 cycles
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h03);
        @(negedge clk); pa_in = 1'b1;
        repeat (640) @(negedge clk);
        pa_in = 1'b0;
        repeat (8) @(negedge clk);
        rd(2'd0, v); chk("R3 gated high ticks", v, 8'd10);
        rd(2'd2, v); chk("R7 trailing edge flag", v, 8'h02);
        repeat (300) @(negedge clk);
        rd(2'd0, v); chk("R3 inactive holds", v, 8'd10);

        // R3 gated, active low, 320 cycles
        wr(2'd1, 8'h06);
        @(negedge clk); pa_in = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h07);
        @(negedge clk); pa_in = 1'b0;
        repeat (320) @(negedge clk);
        pa_in = 1'b1;
        repeat (8) @(negedge clk);
        rd(2'd0, v); chk("R3 gated low ticks", v, 8'd5);

        // R5 write wins over same-cycle tick
        wr(2'd1, 8'h03);
        begin
            int bad = 0;
            @(negedge clk);
            bus_addr = 2'd0; bus_wdata = 8'h33; bus_wr = 1'b1;
            for (int c = 0; c < 140; c++) begin
                @(negedge clk);
                #1 if (bus_rdata !== 8'h33) bad++;
            end
            bus_wr = 1'b0;
            chk("R5 write priority mismatches", 8'(bad), 8'h00);
        end
        pa_in = 1'b0;
        repeat (4) @(negedge clk);

        // R8 / R9: set both flags via wrap
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h01);
        pulse();
        repeat (4) @(negedge clk);
        rd(2'd2, v); chk("R6 wrap and edge set", v, 8'h03);
        wr(2'd1, 8'h11);
        @(negedge clk); chk("R9 irq edge enabled", {7'b0, irq}, 8'h01);
        wr(2'd2, 8'h01);
        rd(2'd2, v); chk("R8 clear wrap only", v, 8'h02);
        wr(2'd1, 8'h09);
        @(negedge clk); chk("R9 irq wrap enable, wrap clear", {7'b0, irq}, 8'h00);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R8 zero write no effect", v, 8'h02);
        wr(2'd2, 8'h02);
        rd(2'd2, v); chk("R8 clear edge", v, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule